// File: doc/BRIEF.md
# Hashed Page Table Entry Installer

This block places one address translation into a hashed page table kept in ordinary memory. The table is divided into groups of eight two-word slots. Each slot holds a high word, which identifies the translation and carries a valid flag, and a low word, which holds the translated data. The caller supplies a context number, the page number of an effective address (address bits 31..12), a prepared low word and a flag. The flag says that an entry for this page may already be present in the table. The block derives a 24-bit segment identifier from the context and the page number. From that identifier it computes two candidate groups. It then walks memory one read at a time to find where the entry goes and writes it back.

When the flag is set, the block first looks for an existing entry, and a hit refreshes only that slot's low word. Otherwise, or after a miss, it takes the first free slot, looking in the primary group before the secondary one. When both groups are full, it evicts a slot of the primary group chosen by a round-robin pointer. A new entry is committed in three writes, so that no reader ever sees a half-written entry marked valid. Two statistics counters record how many existing-entry searches ran and how often the primary group was full.

Top module: `hpt_insert`

## Requirements
- R1: The segment identifier is the low 24 bits of context × 14352 plus E × 273, where E is page-number bits 19..16. The primary hash is (segment identifier XOR page-number bits 15..0), kept to HASH_BITS bits. The secondary hash is the bitwise inverse of the primary hash within those bits. A group starts at TABLE_BASE + hash × 64. Slot k of a group has its high word at group + 8k and its low word at group + 8k + 4.
- R2: A high word holds, from bit 31 down: the valid flag (bit 31), the segment identifier (bits 30..7), a secondary flag (bit 6, set only for slots of the secondary group) and page-number bits 15..10 (bits 5..0).
- R3: With the may-exist flag set, the block reads the high words of primary slots 0..7 and then secondary slots 0..7 and compares each with the target, whose secondary flag matches the group being read. At the first equal word it writes only the low word of that slot, then finishes.
- R4: With the may-exist flag clear, no existing-entry search takes place, even if a matching entry exists. The search counter is unchanged.
- R5: The free-slot search reads primary slots 0..7 and then secondary slots 0..7, and takes the first slot whose high word has bit 31 clear.
- R6: When all sixteen slots are valid, the victim pointer first advances by one modulo 8, and the new value selects the primary slot to overwrite. The pointer is 0 after reset, so the first eviction uses slot 1, the next slot 2, and so on.
- R7: A new entry is written as the high word with bit 31 clear, then the low word, then the high word with bit 31 set, in three consecutive cycles to the same slot.
- R8: search_count increases by one for each request with the may-exist flag set. full_count increases by one each time the primary group holds no free slot during a free-slot search.
- R9: At most one read is outstanding. After a read request, no further request is issued before its response arrives.
- R10: done is a single-cycle pulse at the end of a request. busy is high from the cycle after start until done. A start while busy is ignored.
- R11: After reset, busy, done and mem_req are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| ctx_id | input | CTX_W | Context number |
| epn | input | 20 | Effective page number (address bits 31..12) |
| lo_word | input | 32 | Prepared low translation word |
| may_exist | input | 1 | An entry for this page may already be in the table |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request strobe (one cycle per access) |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| search_count | output | STAT_W | Existing-entry searches performed |
| full_count | output | STAT_W | Times the primary group was full |

## Verification
The checker watches every cycle for four things: the single-read discipline, the strict ordering of the three commit writes to one slot, the confinement of every access to the table, and the one-step growth of both counters. Whether the right slot was chosen can only be shown by the bench scenarios, because that depends on table contents. These cover a first-free slot in the middle of a group, overflow into the secondary group, repeated round-robin evictions, a hit in the secondary group, and a preloaded match that a request with the flag clear must ignore. The same holds for the exact hashed addresses and the exact high-word encodings, which the bench's scoreboard predicts from the formulas.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int SLOTS       = 8;
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int ENTRY_SHIFT = 3;   // 8 bytes per slot
    localparam int GROUP_SHIFT = 6;   // 64 bytes per group
    localparam int VSID_W      = 24;
    localparam int CTX_SKEW    = 897 * 16;
    localparam int SEG_SKEW    = 'h111;
    localparam int VALID_BIT   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WT,
        ST_WHI0,
        ST_WLO,
        ST_WHI1,
        ST_DONE
    } st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int CTX_W     = 20,
    parameter int HASH_BITS = 12
) (
    input  logic [CTX_W-1:0]     ctx,
    input  logic [19:0]          epn,
    output logic [VSID_W-1:0]    vsid,
    output logic [5:0]           api,
    output logic [HASH_BITS-1:0] hash_p,
    output logic [HASH_BITS-1:0] hash_s
);
    // segment id from context and the top four address bits
    assign vsid   = VSID_W'(32'(ctx) * 32'(CTX_SKEW) + 32'(epn[19:16]) * 32'(SEG_SKEW));
    assign api    = epn[15:10];
    assign hash_p = vsid[HASH_BITS-1:0] ^ HASH_BITS'(epn[15:0]);
    assign hash_s = ~hash_p;
endmodule

// File: rtl/hpt_slot_addr.sv
module hpt_slot_addr
    import hpt_pkg::*;
#(
    parameter logic [31:0] TABLE_BASE = 32'h0018_0000,
    parameter int          HASH_BITS  = 12
) (
    input  logic [HASH_BITS-1:0] hash,
    input  logic [SLOT_W-1:0]    idx,
    output logic [31:0]          hi_addr,
    output logic [31:0]          lo_addr
);
    assign hi_addr = TABLE_BASE + (32'(hash) << GROUP_SHIFT) + (32'(idx) << ENTRY_SHIFT);
    assign lo_addr = hi_addr + 32'd4;
endmodule

// File: rtl/hpt_insert.sv
module hpt_insert
    import hpt_pkg::*;
#(
    parameter int          CTX_W      = 20,
    parameter int          HASH_BITS  = 12,
    parameter logic [31:0] TABLE_BASE = 32'h0018_0000,
    parameter int          STAT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic [19:0]       epn,
    input  logic [31:0]       lo_word,
    input  logic              may_exist,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [STAT_W-1:0] search_count,
    output logic [STAT_W-1:0] full_count
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        st_e               st;
        logic [CTX_W-1:0]  ctx;
        logic [19:0]       epn;
        logic [31:0]       lo;
        logic              sec;
        logic [SLOT_W-1:0] idx;
        logic              matching;
        logic              full_commit;
        logic [SLOT_W-1:0] victim;
        logic [STAT_W-1:0] n_search;
        logic [STAT_W-1:0] n_full;
    } regs_t;

    regs_t r_q, r_d;

    logic [VSID_W-1:0]    vsid;
    logic [5:0]           api;
    logic [HASH_BITS-1:0] hash_p, hash_s, hash_sel;
    logic [31:0]          hi_addr, lo_addr;
    logic [31:0]          hi_cur;
    logic                 last;

    hpt_hash #(
        .CTX_W    (CTX_W),
        .HASH_BITS(HASH_BITS)
    ) u_hash (
        .ctx   (r_q.ctx),
        .epn   (r_q.epn),
        .vsid  (vsid),
        .api   (api),
        .hash_p(hash_p),
        .hash_s(hash_s)
    );

    assign hash_sel = r_q.sec ? hash_s : hash_p;

    hpt_slot_addr #(
        .TABLE_BASE(TABLE_BASE),
        .HASH_BITS (HASH_BITS)
    ) u_addr (
        .hash   (hash_sel),
        .idx    (r_q.idx),
        .hi_addr(hi_addr),
        .lo_addr(lo_addr)
    );

    // target high word for the group currently being visited
    assign hi_cur = {1'b1, vsid, r_q.sec, api};
    assign last   = (r_q.idx == LAST_SLOT);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.ctx         = ctx_id;
                    r_d.epn         = epn;
                    r_d.lo          = lo_word;
                    r_d.sec         = 1'b0;
                    r_d.idx         = '0;
                    r_d.matching    = may_exist;
                    r_d.full_commit = 1'b1;
                    if (may_exist) r_d.n_search = r_q.n_search + 1'b1;
                    r_d.st          = ST_RD;
                end
            end
            ST_RD: r_d.st = ST_WT;
            ST_WT: begin
                if (mem_rvalid) begin
                    if (r_q.matching) begin
                        if (mem_rdata == hi_cur) begin
                            r_d.full_commit = 1'b0;
                            r_d.st          = ST_WLO;
                        end else if (last) begin
                            r_d.idx = '0;
                            if (!r_q.sec) begin
                                r_d.sec = 1'b1;
                            end else begin
                                r_d.sec      = 1'b0;
                                r_d.matching = 1'b0;
                            end
                            r_d.st = ST_RD;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                            r_d.st  = ST_RD;
                        end
                    end else begin
                        if (!mem_rdata[VALID_BIT]) begin
                            r_d.st = ST_WHI0;
                        end else if (last) begin
                            if (!r_q.sec) begin
                                r_d.sec    = 1'b1;
                                r_d.idx    = '0;
                                r_d.n_full = r_q.n_full + 1'b1;
                                r_d.st     = ST_RD;
                            end else begin
                                r_d.sec    = 1'b0;
                                r_d.victim = r_q.victim + 1'b1;
                                r_d.idx    = r_q.victim + 1'b1;
                                r_d.st     = ST_WHI0;
                            end
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                            r_d.st  = ST_RD;
                        end
                    end
                end
            end
            ST_WHI0: r_d.st = ST_WLO;
            ST_WLO:  r_d.st = r_q.full_commit ? ST_WHI1 : ST_DONE;
            ST_WHI1: r_d.st = ST_DONE;
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = hi_addr;
        mem_wdata = '0;
        unique case (r_q.st)
            ST_RD: mem_req = 1'b1;
            ST_WHI0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, hi_cur[30:0]};
            end
            ST_WLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lo_addr;
                mem_wdata = r_q.lo;
            end
            ST_WHI1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hi_cur;
            end
            default: ;
        endcase
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign done         = (r_q.st == ST_DONE);
    assign search_count = r_q.n_search;
    assign full_count   = r_q.n_full;
endmodule

// File: rtl/hpt_insert_chk.sv
module hpt_insert_chk #(
    parameter int          HASH_BITS  = 12,
    parameter logic [31:0] TABLE_BASE = 32'h0018_0000,
    parameter int          STAT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [STAT_W-1:0] search_count,
    input logic [STAT_W-1:0] full_count
);
    localparam logic [31:0] TABLE_END = TABLE_BASE + (32'd64 << HASH_BITS);

    // R10: completion strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy only drops right after done
    a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R9: a read is never followed directly by another request
    a_r9_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

    // R7: a high word marked valid follows the low word of the same slot
    a_r7_valid_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_addr[2] && mem_wdata[31])
        |-> ($past(mem_req && mem_we) && $past(mem_addr) == mem_addr + 32'd4));

    // R7: an invalid high word is followed by the low word of that slot
    a_r7_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_addr[2] && !mem_wdata[31])
        |=> (mem_req && mem_we && mem_addr == $past(mem_addr) + 32'd4));

    // R1: every access stays word aligned inside the table
    a_r1_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr >= TABLE_BASE && mem_addr < TABLE_END && mem_addr[1:0] == 2'b00));

    // R8: counters move by exactly one
    a_r8_search_step: assert property (@(posedge clk) disable iff (!rst_n)
        (search_count != $past(search_count)) |-> (search_count == STAT_W'($past(search_count) + 1'b1)));

    a_r8_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        (full_count != $past(full_count)) |-> (full_count == STAT_W'($past(full_count) + 1'b1)));
endmodule

bind hpt_insert hpt_insert_chk #(
    .HASH_BITS (HASH_BITS),
    .TABLE_BASE(TABLE_BASE),
    .STAT_W    (STAT_W)
) u_hpt_insert_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .search_count(search_count),
    .full_count  (full_count)
);

// File: tb/test_hpt_insert.sv
module test_hpt_insert;
    localparam int          CLK_PERIOD = 10;
    localparam int          CTX_W      = 20;
    localparam int          HB         = 12;
    localparam logic [31:0] BASE       = 32'h0018_0000;
    localparam int          STAT_W     = 16;
    localparam logic [31:0] HMASK      = (32'd1 << HB) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CTX_W-1:0]  ctx_id = '0;
    logic [19:0]       epn = '0;
    logic [31:0]       lo_word = '0;
    logic              may_exist = 1'b0;
    logic              busy, done, mem_req, mem_we;
    logic [31:0]       mem_addr, mem_wdata;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic [STAT_W-1:0] search_count, full_count;

    int tests = 0;
    int fails = 0;
    int exp_search = 0;
    int exp_full = 0;
    int exp_victim = 0;
    int wr_count = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    hpt_insert #(
        .CTX_W(CTX_W), .HASH_BITS(HB), .TABLE_BASE(BASE), .STAT_W(STAT_W)
    ) i_hpt_insert (
        .clk(clk), .rst_n(rst_n), .start(start), .ctx_id(ctx_id), .epn(epn),
        .lo_word(lo_word), .may_exist(may_exist), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .search_count(search_count), .full_count(full_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // reference formulas (R1, R2)
    function automatic logic [23:0] f_vsid(input logic [CTX_W-1:0] c, input logic [19:0] p);
        logic [31:0] s;
        s = 32'(c) * 32'd14352 + 32'(p[19:16]) * 32'd273;
        return s[23:0];
    endfunction
    function automatic logic [31:0] f_hash(input logic [CTX_W-1:0] c, input logic [19:0] p);
        return (32'(f_vsid(c, p)) ^ 32'(p[15:0])) & HMASK;
    endfunction
    function automatic logic [31:0] f_grp(input logic [31:0] h);
        return BASE + (h << 6);
    endfunction
    function automatic logic [31:0] f_hi(input logic [CTX_W-1:0] c, input logic [19:0] p, input bit h);
        return {1'b1, f_vsid(c, p), h, p[15:10]};
    endfunction
    function automatic logic [31:0] prim_grp(input logic [CTX_W-1:0] c, input logic [19:0] p);
        return f_grp(f_hash(c, p));
    endfunction
    function automatic logic [31:0] sec_grp(input logic [CTX_W-1:0] c, input logic [19:0] p);
        return f_grp(~f_hash(c, p) & HMASK);
    endfunction

    task automatic push(input logic [31:0] a, input logic [31:0] d, input string t);
        q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
    endtask
    task automatic push3(input logic [31:0] a, input logic [31:0] hi, input logic [31:0] lo, input string t);
        push(a, hi & 32'h7fff_ffff, {t, " R7 invalid high"});
        push(a + 4, lo, {t, " R7 low"});
        push(a, hi, {t, " R7 valid high"});
    endtask

    // memory model and scoreboard monitor
    int          rd_wait = 0;
    logic [31:0] rd_val = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rd_wait > 0) begin
            rd_wait--;
            if (rd_wait == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_val;
            end
        end
        if (rst_n && mem_req) begin
            if (mem_we) begin
                wr_count++;
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    logic [31:0] ea, ed;
                    string t;
                    ea = q_addr.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
                    chk(mem_addr == ea && mem_wdata == ed, t, "write addr/data",
                        {mem_addr, mem_wdata}, {ea, ed});
                end
                mem[mem_addr] = mem_wdata;
            end else begin
                chk(rd_wait == 0, "R9", "read while read pending", 64'(rd_wait), 64'h0);
                rd_val  = rd(mem_addr);
                rd_wait = 2;
            end
        end
    end

    // driver: predicts the writes, then runs the request
    task automatic do_insert(input logic [CTX_W-1:0] c, input logic [19:0] p,
                             input logic [31:0] lo, input bit may, input bit poke, input string t);
        logic [31:0] pg, sg, a;
        bit found;
        int wr_before;
        pg = prim_grp(c, p);
        sg = sec_grp(c, p);
        found = 0;
        if (may) begin
            exp_search++;
            for (int s = 0; s < 16 && !found; s++) begin
                a = ((s < 8) ? pg : sg) + 32'(s % 8) * 8;
                if (rd(a) == f_hi(c, p, s >= 8)) begin
                    push(a + 4, lo, {t, " R3 low only"});
                    found = 1;
                end
            end
        end
        if (!found) begin
            for (int s = 0; s < 16 && !found; s++) begin
                a = ((s < 8) ? pg : sg) + 32'(s % 8) * 8;
                if (!rd(a)[31]) begin
                    if (s >= 8) exp_full++;
                    push3(a, f_hi(c, p, s >= 8), lo, {t, " R5"});
                    found = 1;
                end
            end
        end
        if (!found) begin
            exp_full++;
            exp_victim = (exp_victim + 1) % 8;
            push3(pg + 32'(exp_victim) * 8, f_hi(c, p, 1'b0), lo, {t, " R6"});
        end
        wr_before = wr_count;
        @(negedge clk);
        start = 1'b1; ctx_id = c; epn = p; lo_word = lo; may_exist = may;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", {t, " busy after start"}, 64'(busy), 64'h1);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; ctx_id = c + 1; epn = p ^ 20'h00f0f; lo_word = ~lo; may_exist = ~may;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R10", {t, " done single pulse"}, 64'(done), 64'h0);
        chk(busy == 1'b0, "R10", {t, " idle after done"}, 64'(busy), 64'h0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(busy == 1'b0 && wr_count == wr_before + 3, "R10", {t, " start while busy ignored"},
                64'(wr_count - wr_before), 64'h3);
        end
        chk(q_addr.size() == 0, "R3", {t, " all predicted writes seen"}, 64'(q_addr.size()), 64'h0);
        chk(search_count == STAT_W'(exp_search), "R8", {t, " search count"}, 64'(search_count), 64'(exp_search));
        chk(full_count == STAT_W'(exp_full), "R8", {t, " full count"}, 64'(full_count), 64'(exp_full));
    endtask

    task automatic fill(input logic [31:0] g, input int from, input int to);
        for (int s = from; s <= to; s++) mem[g + 32'(s) * 8] = 32'h8000_0000 | 32'(s * 3 + 1);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R10 watchdog: actual busy=%0d expected 0", busy);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [CTX_W-1:0] c;
        logic [19:0]      p;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0 && done == 0 && mem_req == 0, "R11", "control outputs in reset",
            {61'h0, busy, done, mem_req}, 64'h0);
        chk(search_count == 0 && full_count == 0, "R11", "counters in reset",
            {search_count, full_count}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mem_req == 0, "R11", "idle after reset", {busy, mem_req}, 2'b00);

        // R1 R2 R5 R7: empty table, first primary slot
        do_insert(20'd5, 20'h12345, 32'hcafe_0001, 1'b0, 1'b0, "T1");
        // R3: same page refreshed, hit in primary slot 0
        do_insert(20'd5, 20'h12345, 32'hcafe_0002, 1'b1, 1'b0, "T2");

        // R5: first free slot in the middle of the primary group
        mem.delete();
        c = 20'h00abc; p = 20'hf00ff;
        fill(prim_grp(c, p), 0, 2);
        do_insert(c, p, 32'h1111_0003, 1'b0, 1'b0, "T3");

        // R5 R8: primary full, secondary slot 0 with the secondary flag
        mem.delete();
        fill(prim_grp(c, p), 0, 7);
        do_insert(c, p, 32'h1111_0004, 1'b0, 1'b0, "T4");

        // R6: both groups full, evictions go to slots 1 then 2 of the primary group
        mem.delete();
        fill(prim_grp(c, p), 0, 7);
        fill(sec_grp(c, p), 0, 7);
        do_insert(c, p, 32'h2222_0005, 1'b0, 1'b0, "T5 R6 first");
        fill(prim_grp(c, p), 0, 7);
        do_insert(c, p, 32'h2222_0006, 1'b0, 1'b0, "T6 R6 second");

        // R3: hit in secondary slot 5; primary holds the word with the wrong secondary flag
        mem.delete();
        c = 20'd7; p = 20'h0abcd;
        mem[prim_grp(c, p) + 16] = f_hi(c, p, 1'b1);
        mem[sec_grp(c, p) + 40]  = f_hi(c, p, 1'b1);
        do_insert(c, p, 32'h3333_0007, 1'b1, 1'b0, "T7");

        // R3 R5: flag set but nothing matches, falls back to free slot
        mem.delete();
        c = 20'hfffff; p = 20'h7a5c3;
        fill(prim_grp(c, p), 0, 0);
        do_insert(c, p, 32'h4444_0008, 1'b1, 1'b0, "T8");

        // R4: matching entry present but flag clear, no search, slot 0 rewritten in full
        mem.delete();
        c = 20'd9; p = 20'h31337;
        mem[prim_grp(c, p) + 32] = f_hi(c, p, 1'b0);
        do_insert(c, p, 32'h5555_0009, 1'b0, 1'b0, "T9 R4");

        // R10: a start pulse during a request is ignored
        mem.delete();
        do_insert(20'd3, 20'h80001, 32'h6666_000a, 1'b0, 1'b1, "T10");

        // R6: pointer keeps rotating across requests
        mem.delete();
        c = 20'd2; p = 20'h44444;
        fill(prim_grp(c, p), 0, 7);
        fill(sec_grp(c, p), 0, 7);
        do_insert(c, p, 32'h7777_000b, 1'b1, 1'b0, "T11 R6 third");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule